// File: doc/BRIEF.md
# Quarter-Duty LCD Waveform Sequencer

This block generates the drive-level selections for a segment LCD panel that is multiplexed four ways and biased at one third. It produces a 2-bit level code for each of 4 common lines and 50 segment lines. External analog switches turn each code into one of four voltages: the full LCD supply, two thirds of it, one third of it, or ground. A strobe from an oscillator divider paces the block. One frame spans 192 strobes. The frame is split into four common phases, and each phase is split into a positive half and a negative half of 24 strobes each, so the panel sees no net DC.

The 200 display bits come from a latch outside the block. Four bits belong to each segment, one for each common phase. An active-high display-enable input blanks the whole panel when it is low, which forces every line to ground. The phase counter keeps running while the panel is blanked, and the display data outside the block is left unchanged.

Top module: `lcd_quarter_duty_seq`

## Requirements
- R1: After reset, the sequencer sits in common phase 0, positive half. With display enabled, `com_lvl` reads 8'h57.
- R2: The sequencer advances only on a clock edge where `tick` is high. A half lasts exactly 24 ticks, so 23 ticks leave the outputs unchanged.
- R3: Halves run in this order: phase 0 positive, phase 0 negative, phase 1 positive, and so on up to phase 3 negative. After 192 ticks the sequence wraps to phase 0 positive.
- R4: Level codes are 00 = ground, 01 = one third, 10 = two thirds, 11 = full supply. In a positive half, the selected common drives 11 and every other common drives 01.
- R5: In a negative half, the selected common drives 00 and every other common drives 10.
- R6: Segment k (0 to 49) is lit during phase p (0 to 3) when `disp_bits[4*k+p]` is 1.
- R7: In a positive half, a lit segment drives 00 and an unlit segment drives 10. In a negative half, a lit segment drives 11 and an unlit segment drives 01.
- R8: While `disp_en` is low, every common and segment code is 00, but ticks still advance the phase counter. When `disp_en` returns high, the outputs show the half that the counter has reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe from the oscillator divider |
| disp_en | input | 1 | High shows the display, low blanks it |
| disp_bits | input | 200 | Latched display data; bit 4k+p lights segment k in phase p |
| com_lvl | output | 8 | Level code of common i at bits [2i+1:2i] |
| seg_lvl | output | 100 | Level code of segment k at bits [2k+1:2k] |

## Verification
All level codes are decoded combinationally from the phase registers. A strobe therefore shows up in the outputs at the same clock edge that captures it, and a change of `disp_en` or of the data shows up with no clock at all. The bench drives every input on the falling edge and samples on the next falling edge. By then the rising edge that consumes a strobe has already passed, and no decoded output is still settling. Checks of the 23-tick boundary and of idle cycles confirm that nothing moves early.

// File: rtl/lcd_quarter_duty_seq.sv
module lcd_quarter_duty_seq #(
  parameter int NUM_COM    = 4,
  parameter int NUM_SEG    = 50,
  parameter int HALF_TICKS = 24
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic                         disp_en,
  input  logic [NUM_COM*NUM_SEG-1:0]   disp_bits,
  output logic [2*NUM_COM-1:0]         com_lvl,
  output logic [2*NUM_SEG-1:0]         seg_lvl
);
  localparam int SUB_W = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam int PH_W  = (NUM_COM > 1) ? $clog2(NUM_COM) : 1;
  localparam logic [1:0] LVL_VSS = 2'b00;
  localparam logic [1:0] LVL_V2  = 2'b01;
  localparam logic [1:0] LVL_V1  = 2'b10;
  localparam logic [1:0] LVL_V0  = 2'b11;

  logic [SUB_W-1:0] sub_q;
  logic             neg_q;
  logic [PH_W-1:0]  ph_q;

  wire half_end = (sub_q == SUB_W'(HALF_TICKS - 1));
  wire last_ph  = (ph_q == PH_W'(NUM_COM - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_q <= '0;
      neg_q <= 1'b0;
      ph_q  <= '0;
    end else if (tick) begin
      if (half_end) begin
        sub_q <= '0;
        neg_q <= ~neg_q;
        if (neg_q) ph_q <= last_ph ? '0 : ph_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  wire [1:0] com_sel   = neg_q ? LVL_VSS : LVL_V0;
  wire [1:0] com_unsel = neg_q ? LVL_V1  : LVL_V2;
  wire [1:0] seg_on    = neg_q ? LVL_V0  : LVL_VSS;
  wire [1:0] seg_off   = neg_q ? LVL_V2  : LVL_V1;

  for (genvar i = 0; i < NUM_COM; i++) begin : g_com
    assign com_lvl[2*i +: 2] = !disp_en ? LVL_VSS :
                               (ph_q == PH_W'(i)) ? com_sel : com_unsel;
  end

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    wire [NUM_COM-1:0] grp = disp_bits[NUM_COM*k +: NUM_COM];
    assign seg_lvl[2*k +: 2] = !disp_en ? LVL_VSS :
                               grp[ph_q] ? seg_on : seg_off;
  end
endmodule

// File: rtl/lcd_quarter_duty_seq_chk.sv
module lcd_quarter_duty_seq_chk #(
  parameter int NUM_COM = 4,
  parameter int NUM_SEG = 50
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick,
  input logic                   disp_en,
  input logic [2*NUM_COM-1:0]   com_lvl,
  input logic [2*NUM_SEG-1:0]   seg_lvl
);
  logic [NUM_COM-1:0] com_lo, com_hi;
  logic [NUM_SEG-1:0] seg_lo;

  for (genvar i = 0; i < NUM_COM; i++) begin : g_c
    assign com_lo[i] = com_lvl[2*i];
    assign com_hi[i] = com_lvl[2*i+1];
  end
  for (genvar k = 0; k < NUM_SEG; k++) begin : g_s
    assign seg_lo[k] = seg_lvl[2*k];
  end

  assert_blank_vss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |-> (com_lvl == '0 && seg_lvl == '0));

  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && !tick) |=> (!disp_en || $stable(com_lvl)));

  assert_com_same_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> (com_lo == '0 || com_lo == '1));

  assert_pos_one_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && com_lo == '1) |-> $countones(com_hi) == 1);

  assert_neg_one_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && com_lo == '0) |-> $countones(com_hi) == NUM_COM - 1);

  assert_seg_polarity_R7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> seg_lo == {NUM_SEG{~com_lo[0]}});
endmodule

bind lcd_quarter_duty_seq lcd_quarter_duty_seq_chk #(
  .NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)
) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .disp_en(disp_en),
  .com_lvl(com_lvl), .seg_lvl(seg_lvl)
);

// File: tb/lcd_quarter_duty_seq_tb.sv
module lcd_quarter_duty_seq_tb_top;
  localparam int NC = 4;
  localparam int NS = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic disp_en = 1'b1;
  logic [NC*NS-1:0] disp_bits;
  logic [2*NC-1:0] com_lvl;
  logic [2*NS-1:0] seg_lvl;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lcd_quarter_duty_seq dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .disp_en(disp_en),
    .disp_bits(disp_bits), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  // expected common codes per half, in sequence order: phase 0 pos, phase 0 neg, ...
  localparam logic [7:0] COM_TBL [8] = '{8'h57, 8'hA8, 8'h5D, 8'hA2,
                                         8'h75, 8'h8A, 8'hD5, 8'h2A};

  function automatic logic [2*NS-1:0] exp_seg(input logic [NC*NS-1:0] d,
                                             input int ph, input bit neg);
    logic [2*NS-1:0] r;
    for (int k = 0; k < NS; k++) begin
      if (d[NC*k + ph]) r[2*k +: 2] = neg ? 2'b11 : 2'b00;
      else              r[2*k +: 2] = neg ? 2'b01 : 2'b10;
    end
    return r;
  endfunction

  function automatic logic [NC*NS-1:0] pat_a();
    logic [NC*NS-1:0] r;
    for (int k = 0; k < NS; k++) r[NC*k +: NC] = 4'(k % 16);
    return r;
  endfunction

  task automatic chk_com(input string req, input logic [7:0] exp);
    n_chk++;
    if (com_lvl !== exp) begin
      n_fail++;
      $display("FAIL %s com_lvl actual=%h expected=%h", req, com_lvl, exp);
    end
  endtask

  task automatic chk_seg(input string req, input logic [2*NS-1:0] exp);
    n_chk++;
    if (seg_lvl !== exp) begin
      n_fail++;
      $display("FAIL %s seg_lvl actual=%h expected=%h", req, seg_lvl, exp);
    end
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    disp_bits = pat_a();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_com("R1", 8'h57);
    chk_seg("R1", exp_seg(disp_bits, 0, 1'b0));

    // vector walk through one frame: R3 order, R4/R5 commons, R6/R7 segments, R2 boundary
    for (int s = 0; s < 8; s++) begin
      chk_com((s % 2) ? "R5" : "R4", COM_TBL[s]);
      chk_seg("R6_R7", exp_seg(disp_bits, s / 2, (s % 2) == 1));
      do_ticks(23);
      chk_com("R2", COM_TBL[s]);
      do_ticks(1);
    end
    chk_com("R3", 8'h57);

    // R2 idle cycles do not advance
    repeat (10) @(negedge clk);
    chk_com("R2", 8'h57);

    // R6 inverted data in phase 1 positive
    do_ticks(48);
    disp_bits = ~pat_a();
    @(negedge clk);
    chk_com("R3", 8'h5D);
    chk_seg("R6", exp_seg(disp_bits, 1, 1'b0));

    // R8 blanking, counter keeps running
    disp_en = 1'b0;
    @(negedge clk);
    chk_com("R8", 8'h00);
    chk_seg("R8", '0);
    do_ticks(24);
    chk_com("R8", 8'h00);
    chk_seg("R8", '0);
    disp_en = 1'b1;
    @(negedge clk);
    chk_com("R8", 8'hA2);
    chk_seg("R8", exp_seg(disp_bits, 1, 1'b1));

    // R1 reset mid-frame
    do_ticks(30);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_com("R1", 8'h57);
    chk_seg("R1", exp_seg(disp_bits, 0, 1'b0));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule